// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Unit

This unit moves a 16-bit or 32-bit register image to or from an 8-bit peripheral that sits on one byte lane of a 16-bit bus. The image is split into bytes. Each byte is sent to, or fetched from, every second address, so that all accesses land on the same lane. The operand address is a base address plus a signed 16-bit displacement. The parity of that address picks the lane for the whole transfer: an even address uses the upper lane and an odd address uses the lower lane.

A command is given by a one-cycle `start` together with a 3-bit operation code, the base, the displacement and the register value. The unit runs one byte access at a time and waits for an acknowledge after each one. When the last byte completes, `done` pulses for one cycle. For a load, `reg_we` pulses in the same cycle and the new register value appears on `reg_out`. The unit has no condition flags, and no transfer touches any.

Top module: `altbyte_xfer`

## Requirements
- R1: The first access goes to base plus the displacement sign-extended to the address width. The sum wraps modulo the address width.
- R2: Operation codes are 3'b100 (load word), 3'b101 (load long), 3'b110 (store word) and 3'b111 (store long). Bit 0 selects long and bit 1 selects store. A start with bit 2 clear is ignored: no access is made and no `done` pulse follows.
- R3: A word transfer makes exactly 2 byte accesses and a long transfer makes exactly 4. Each access address is the previous one plus 2.
- R4: A store sends the most significant byte of the moved portion first and the least significant byte last. The moved portion is bits 31:0 for a long and bits 15:0 for a word.
- R5: An even start address selects the upper lane (`bus_lane`=2'b10, data on bits 15:8). An odd start address selects the lower lane (`bus_lane`=2'b01, data on bits 7:0). The lane stays the same for the whole transfer. Store data carries zero on the unused lane, and load data is taken only from the selected lane.
- R6: A long load places the first fetched byte in bits 31:24 and the last fetched byte in bits 7:0 of `reg_out`.
- R7: A word load places the two fetched bytes in bits 15:0 of `reg_out`, first byte in the upper position. Bits 31:16 keep the value `reg_in` had at start.
- R8: A request holds its address and lane steady until `bus_ack` is seen.
- R9: `done` pulses for exactly one cycle, in the cycle after the last acknowledge. `reg_we` pulses only in that cycle and only for loads.
- R10: A start that arrives while a transfer is running is ignored. A start that arrives in the cycle `done` is high is accepted.
- R11: After reset the unit is idle: `bus_req`, `busy`, `done` and `reg_we` are low, and `reg_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| opmode | input | 3 | Operation code |
| base_addr | input | AW | Base address |
| disp | input | DISP_W | Signed displacement |
| reg_in | input | DW | Register value at start |
| busy | output | 1 | Transfer in progress |
| bus_req | output | 1 | Byte access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Byte access address |
| bus_lane | output | 2 | Lane select, {upper, lower} |
| bus_wdata | output | BUS_W | Write data on the selected lane |
| bus_rdata | input | BUS_W | Read data from the bus |
| bus_ack | input | 1 | Access acknowledge |
| done | output | 1 | Transfer complete pulse |
| reg_we | output | 1 | Register update strobe (loads) |
| reg_out | output | DW | Updated register value |

## Verification
The overlap of interest is the completion of one transfer and the acceptance of the next. `done` and a new `start` share a cycle: the bench raises `start` in the same cycle in which it sees `done`. It then judges the new command by its full list of expected bus accesses, and judges the finished load by its register value. A second overlap is a `start` that arrives in the middle of a long load. Any stray access from such a start is caught by the scoreboard, because an access that arrives with no item queued, or with the wrong address, lane or data, is a failure.

// File: rtl/altb_pkg.sv
package altb_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} altb_state_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/altb_addr_gen.sv
module altb_addr_gen #(
  parameter int AW     = 24,
  parameter int DISP_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [AW-1:0]     base,
  input  logic [DISP_W-1:0] disp,
  input  logic [CNT_W-1:0]  len,
  output logic [AW-1:0]     addr,
  output logic              last
);
  localparam int EXT_W = AW - DISP_W;

  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      addr_q <= base + disp_ext;
      cnt_q  <= len;
    end else if (step) begin
      addr_q <= addr_q + AW'(2);
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign addr = addr_q;
  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/altb_byte_shifter.sv
module altb_byte_shifter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic [7:0]    in_byte,
  output logic [7:0]    top_byte,
  output logic [DW-1:0] shifted
);
  logic [DW-1:0] data_q;

  assign shifted  = {data_q[DW-9:0], in_byte};
  assign top_byte = data_q[DW-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst)        data_q <= '0;
    else if (load)  data_q <= load_val;
    else if (shift) data_q <= shifted;
  end
endmodule

// File: rtl/altbyte_xfer.sv
module altbyte_xfer #(
  parameter int AW     = 24,
  parameter int DISP_W = 16,
  parameter int DW     = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opmode,
  input  logic [AW-1:0]     base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [DW-1:0]     reg_in,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_lane,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_ack,
  output logic              done,
  output logic              reg_we,
  output logic [DW-1:0]     reg_out
);
  import altb_pkg::*;

  localparam int HALF       = DW / 2;
  localparam int LONG_BYTES = DW / BYTE_W;
  localparam int WORD_BYTES = HALF / BYTE_W;
  localparam int CNT_W      = $clog2(LONG_BYTES) + 1;
  localparam int PAD_W      = BUS_W - BYTE_W;

  altb_state_e     st_q;
  logic            wr_q;
  logic            long_q;
  logic [HALF-1:0] hi_keep_q;

  logic            accept;
  logic            step;
  logic            last;
  logic [DW-1:0]   load_val;
  logic [CNT_W-1:0] len;
  logic [7:0]      lane_byte;
  logic [7:0]      top_byte;
  logic [DW-1:0]   shifted;

  assign accept   = (st_q == ST_IDLE) && start && opmode[2];
  assign step     = (st_q == ST_RUN) && bus_ack;
  assign load_val = opmode[0] ? reg_in : {reg_in[HALF-1:0], {HALF{1'b0}}};
  assign len      = opmode[0] ? CNT_W'(LONG_BYTES) : CNT_W'(WORD_BYTES);

  altb_addr_gen #(.AW(AW), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_addr (
    .clk (clk), .rst (rst), .load (accept), .step (step),
    .base (base_addr), .disp (disp), .len (len),
    .addr (bus_addr), .last (last)
  );

  assign lane_byte = bus_addr[0] ? bus_rdata[BYTE_W-1:0] : bus_rdata[BUS_W-1 -: BYTE_W];

  altb_byte_shifter #(.DW(DW)) u_shift (
    .clk (clk), .rst (rst), .load (accept), .load_val (load_val),
    .shift (step), .in_byte (lane_byte),
    .top_byte (top_byte), .shifted (shifted)
  );

  assign bus_lane  = bus_addr[0] ? 2'b01 : 2'b10;
  assign bus_wdata = bus_addr[0] ? {{PAD_W{1'b0}}, top_byte} : {top_byte, {PAD_W{1'b0}}};
  assign bus_req   = (st_q == ST_RUN);
  assign busy      = (st_q == ST_RUN);
  assign bus_we    = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      wr_q      <= 1'b0;
      long_q    <= 1'b0;
      hi_keep_q <= '0;
      done      <= 1'b0;
      reg_we    <= 1'b0;
      reg_out   <= '0;
    end else begin
      done   <= 1'b0;
      reg_we <= 1'b0;
      if (accept) begin
        st_q      <= ST_RUN;
        wr_q      <= opmode[1];
        long_q    <= opmode[0];
        hi_keep_q <= reg_in[DW-1:HALF];
      end else if (step && last) begin
        st_q <= ST_IDLE;
        done <= 1'b1;
        if (!wr_q) begin
          reg_we  <= 1'b1;
          reg_out <= long_q ? shifted : {hi_keep_q, shifted[HALF-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/altbyte_xfer_chk.sv
module altbyte_xfer_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_lane,
  input logic          done,
  input logic          reg_we
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_lane));

  assert_stride_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req || ((bus_addr - $past(bus_addr)) == AW'(2)));

  assert_one_lane_R5: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> $countones(bus_lane) == 1);

  assert_lane_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req || $stable(bus_lane));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

  assert_we_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> done);

  assert_end_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> bus_req || done);
endmodule

bind altbyte_xfer altbyte_xfer_chk #(.AW(AW)) u_chk (
  .clk (clk), .rst (rst), .bus_req (bus_req), .bus_ack (bus_ack),
  .bus_addr (bus_addr), .bus_lane (bus_lane), .done (done), .reg_we (reg_we)
);

// File: tb/tb_altbyte_xfer.sv
module tb_altbyte_xfer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opmode = 3'b000;
  logic [23:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic [31:0] reg_in = '0;
  logic        busy, bus_req, bus_we, done, reg_we;
  logic [23:0] bus_addr;
  logic [1:0]  bus_lane;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic [31:0] reg_out;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int lat_cnt = 0;
  int cyc = 0;

  typedef struct packed {
    logic [23:0] addr;
    logic        we;
    logic [1:0]  lane;
    logic [7:0]  wb;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  altbyte_xfer dut (
    .clk (clk), .rst (rst), .start (start), .opmode (opmode),
    .base_addr (base_addr), .disp (disp), .reg_in (reg_in),
    .busy (busy), .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_lane (bus_lane), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .bus_ack (bus_ack), .done (done), .reg_we (reg_we), .reg_out (reg_out)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bus slave model and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      lat_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      lat_cnt = 0;
    end else if (bus_req) begin
      if (lat_cnt >= lat) begin
        logic [7:0] b;
        item_t it;
        b = mem_byte(bus_addr);
        bus_rdata = bus_addr[0] ? {~b, b} : {b, ~b};
        bus_ack = 1'b1;
        if (exp_q.size() == 0) begin
          check("R2 R10", "unexpected access addr", {8'h0, bus_addr}, 32'hFFFFFFFF);
        end else begin
          it = exp_q.pop_front();
          check("R1 R3", "access address", {8'h0, bus_addr}, {8'h0, it.addr});
          check("R2", "access direction", {31'h0, bus_we}, {31'h0, it.we});
          check("R5", "lane select", {30'h0, bus_lane}, {30'h0, it.lane});
          if (it.we)
            check("R4 R5", "write data",
                  {16'h0, bus_wdata},
                  {16'h0, it.addr[0] ? {8'h00, it.wb} : {it.wb, 8'h00}});
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Driver: queue expected accesses, pulse start (called at a negedge)
  task automatic start_op(input logic [2:0] op, input logic [23:0] base,
                          input logic [15:0] d, input logic [31:0] rv);
    logic [23:0] a;
    int n;
    a = base + {{8{d[15]}}, d};
    n = op[0] ? 4 : 2;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.addr = a + 24'(2 * i);
      it.we   = op[1];
      it.lane = a[0] ? 2'b01 : 2'b10;
      it.wb   = op[0] ? rv[31 - 8*i -: 8] : rv[15 - 8*i -: 8];
      exp_q.push_back(it);
    end
    opmode = op; base_addr = base; disp = d; reg_in = rv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [31:0] exp_load(input logic [2:0] op, input logic [23:0] base,
                                           input logic [15:0] d, input logic [31:0] rv);
    logic [23:0] a;
    a = base + {{8{d[15]}}, d};
    if (op[0])
      return {mem_byte(a), mem_byte(a + 24'd2), mem_byte(a + 24'd4), mem_byte(a + 24'd6)};
    return {rv[31:16], mem_byte(a), mem_byte(a + 24'd2)};
  endfunction

  task automatic wait_done(input logic is_load, input logic [31:0] exp_reg, input string req);
    int t;
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    check("R9", "done seen", {31'h0, done}, 32'h1);
    check("R9", "reg_we with done", {31'h0, reg_we}, {31'h0, is_load});
    if (is_load) check(req, "register result", reg_out, exp_reg);
    check("R3", "remaining expected accesses", exp_q.size(), 32'h0);
  endtask

  initial begin
    logic [31:0] e;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11", "reset outputs", {28'h0, bus_req, busy, done, reg_we}, 32'h0);
    check("R11", "reset reg_out", reg_out, 32'h0);

    // Long store, even address (R1 R4 R5)
    lat = 0;
    start_op(3'b111, 24'h001000, 16'h0010, 32'hA1B2C3D4);
    wait_done(1'b0, 32'h0, "R4");
    @(negedge clk);

    // Long store, odd address via negative displacement (R1 R5)
    lat = 1;
    start_op(3'b111, 24'h002000, 16'hFFF1, 32'h11223344);
    wait_done(1'b0, 32'h0, "R5");
    @(negedge clk);

    // Word store, even address, slow acknowledge (R4 R8)
    lat = 2;
    start_op(3'b110, 24'h000400, 16'h0000, 32'hDEAD5A6B);
    wait_done(1'b0, 32'h0, "R4");
    @(negedge clk);

    // Long load, even address (R6)
    lat = 1;
    e = exp_load(3'b101, 24'h003000, 16'h0042, 32'h0);
    start_op(3'b101, 24'h003000, 16'h0042, 32'h0);
    wait_done(1'b1, e, "R6");
    @(negedge clk);

    // Word load, odd address, upper half kept (R7 R5)
    lat = 0;
    e = exp_load(3'b100, 24'h004000, 16'h0013, 32'hCAFE9999);
    start_op(3'b100, 24'h004000, 16'h0013, 32'hCAFE9999);
    wait_done(1'b1, e, "R7");
    @(negedge clk);

    // Ignored operation code (R2)
    opmode = 3'b010; reg_in = 32'h55555555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy || done || reg_we) seen++;
      @(negedge clk);
    end
    check("R2", "no activity for bit2 clear", seen, 32'h0);
    check("R2", "reg_out unchanged", reg_out, e);

    // Start while busy is ignored (R10)
    lat = 1;
    e = exp_load(3'b101, 24'h005000, 16'h0100, 32'h0);
    start_op(3'b101, 24'h005000, 16'h0100, 32'h0);
    @(negedge clk);
    @(negedge clk);
    opmode = 3'b111; base_addr = 24'h00F000; reg_in = 32'h12345678; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(1'b1, e, "R10");
    @(negedge clk);
    check("R10", "idle after ignored start", {31'h0, busy}, 32'h0);

    // Back-to-back: new start in the done cycle (R10)
    lat = 0;
    e = exp_load(3'b100, 24'h006000, 16'h0002, 32'hBEEF0000);
    start_op(3'b100, 24'h006000, 16'h0002, 32'hBEEF0000);
    wait_done(1'b1, e, "R7");
    start_op(3'b111, 24'h007001, 16'h0000, 32'h89ABCDEF);
    check("R10", "accepted in done cycle", {31'h0, busy}, 32'h1);
    wait_done(1'b0, 32'h0, "R10");
    @(negedge clk);

    // Address wrap across the top of the space (R1)
    lat = 0;
    start_op(3'b110, 24'hFFFFFE, 16'h0001, 32'h0000A55A);
    wait_done(1'b0, 32'h0, "R1");
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule